// File: doc/BRIEF.md
# Hardware Mutex Semaphore Bank

This block keeps a small set of hardware mutexes that several requesters (bus masters or separate functions sharing one board) use to take turns on shared resources such as a flash device, a PHY management path, a firmware mailbox or an address-window register. Each requester polls a lock address. The read itself tries to take the mutex, and the returned word says whether the attempt succeeded. A read of the matching unlock address gives the mutex back. No write is needed to take or release a mutex.

A separate owner-ID register per mutex lets the holder record its function number, so that any agent can see who last claimed the resource. A status word shows all held/free flags at once without touching them. Each requester has its own port. When several ports issue accesses in the same cycle, the lowest-numbered port is served and the others are refused.

All accesses are registered. A request presented at clock edge k produces its response in the cycle after edge k.

Top module: `hsem_bank`

## Requirements
- R1: Each port's response is registered. `rsp_valid[p]` is 1 in the cycle after edge k exactly when `req_rd[p]` was 1 at edge k. The port's `rsp_rdata` slice is 0 whenever it carries no read result.
- R2: With byte offset 8·N (N = 0..NSEM-1), a read of the lock address of a free mutex N returns 1 and leaves the mutex held.
- R3: A lock read of a mutex that is already held returns 0 and changes no state, even when the requester reading it is the one holding it.
- R4: A read of the unlock address (byte offset 8·N+4) frees mutex N whatever port issues it and returns 0. An unlock read of a free mutex has no effect.
- R5: The owner-ID register of mutex N sits at byte offset 16·NSEM+4·N. A write stores the low IDW bits of the write data. A read returns that value zero-extended. Lock and unlock accesses do not alter it.
- R6: A read of the status word at byte offset 8·NSEM returns the held flag of mutex N in bit N, and 0 in all other bits. This read changes no state.
- R7: Reads of any other offset, including offsets that are not multiples of 4, return 0 and have no side effect. Writes to lock, unlock, status or undefined offsets have no effect.
- R8: When several ports request (read or write) at the same edge, only the lowest-numbered port is served. Every other reading port gets a response with data 0, and the other ports' accesses change no state.
- R9: After reset every mutex is free and every owner-ID register reads 0.
- R10: When a port asserts read and write together, only the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | NPORT | Per-port read strobe |
| req_wr | input | NPORT | Per-port write strobe |
| req_addr | input | NPORT*AW | Per-port byte offset within the bank, port p at bits [p*AW +: AW] |
| req_wdata | input | NPORT*DW | Per-port write data, port p at bits [p*DW +: DW] |
| rsp_valid | output | NPORT | Per-port read response valid |
| rsp_rdata | output | NPORT*DW | Per-port read response data, port p at bits [p*DW +: DW] |

## Verification
The bench drives directed sequences and then a long random mix of lock, unlock, status, owner and stray offsets on two ports. A behavioural model predicts every response. The corner cases it targets are these:
- A second lock read by the current holder must return 0. A reentrant design would answer 1.
- An unlock from the non-holding port must free the mutex. A design that checked ownership would keep it held, and the next status read would show it.
- Two ports hit the same free mutex in the same cycle. A wrong priority would hand the grant to port 1, and a design that served both would return 1 twice.
- Unaligned offsets, the gap above the status word and writes to lock addresses must not change any state. A loose decoder would alias them onto real registers, and later status or owner reads would show the corruption.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LOCK   = 3'd1,
        OP_UNLOCK = 3'd2,
        OP_STATUS = 3'd3,
        OP_OWNER  = 3'd4
    } hsem_op_e;

endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
    import hsem_pkg::*;
#(
    parameter int NSEM = 8,
    parameter int AW   = 8
) (
    input  logic [AW-1:0]                           addr,
    output hsem_op_e                                op,
    output logic [(NSEM > 1 ? $clog2(NSEM) : 1)-1:0] idx
);
    localparam int SW = (NSEM > 1) ? $clog2(NSEM) : 1;
    localparam logic [31:0] PAIR_END = 32'(8 * NSEM);
    localparam logic [31:0] STAT_OFF = 32'(8 * NSEM);
    localparam logic [31:0] OWN_OFF  = 32'(16 * NSEM);
    localparam logic [31:0] OWN_END  = 32'(20 * NSEM);

    logic [31:0] a32;
    logic [31:0] orel;

    always_comb begin
        a32  = 32'(addr);
        orel = a32 - OWN_OFF;
        op   = OP_NONE;
        idx  = '0;
        if ((a32 & 32'd3) == 32'd0) begin
            if (a32 < PAIR_END) begin
                idx = SW'(a32 >> 3);
                op  = ((a32 & 32'd4) != 32'd0) ? OP_UNLOCK : OP_LOCK;
            end else if (a32 == STAT_OFF) begin
                op = OP_STATUS;
            end else if (a32 >= OWN_OFF && a32 < OWN_END) begin
                idx = SW'(orel >> 2);
                op  = OP_OWNER;
            end
        end
    end
endmodule

// File: rtl/hsem_arb.sv
module hsem_arb #(
    parameter int NPORT = 2
) (
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < NPORT; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int NSEM  = 8,
    parameter int NPORT = 2,
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int IDW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      req_rd,
    input  logic [NPORT-1:0]      req_wr,
    input  logic [NPORT*AW-1:0]   req_addr,
    input  logic [NPORT*DW-1:0]   req_wdata,
    output logic [NPORT-1:0]      rsp_valid,
    output logic [NPORT*DW-1:0]   rsp_rdata
);
    localparam int SW = (NSEM > 1) ? $clog2(NSEM) : 1;
    localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;

    typedef struct packed {
        logic [NSEM-1:0]           held;
        logic [NSEM-1:0][IDW-1:0]  owner;
        logic [NPORT-1:0]          vld;
        logic [NPORT-1:0][DW-1:0]  rdata;
    } hsem_state_t;

    hsem_state_t st_d, st_q;

    hsem_op_e        op_p  [NPORT];
    logic [SW-1:0]   idx_p [NPORT];
    logic [NPORT-1:0] gnt;

    hsem_op_e        win_op;
    logic [SW-1:0]   win_idx;
    logic [PW-1:0]   win_pidx;
    logic [DW-1:0]   win_wdata;
    logic [DW-1:0]   win_rdata;
    logic            win_any;
    logic            win_rd;

    // Per-port address decode
    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        hsem_decode #(.NSEM(NSEM), .AW(AW)) u_dec (
            .addr (req_addr[p*AW +: AW]),
            .op   (op_p[p]),
            .idx  (idx_p[p])
        );
        assign rsp_rdata[p*DW +: DW] = st_q.rdata[p];
    end

    // One access per cycle: lowest port index wins
    hsem_arb #(.NPORT(NPORT)) u_arb (
        .req (req_rd | req_wr),
        .gnt (gnt)
    );

    always_comb begin
        win_any   = |gnt;
        win_rd    = 1'b0;
        win_op    = OP_NONE;
        win_idx   = '0;
        win_pidx  = '0;
        win_wdata = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (gnt[p]) begin
                win_rd    = req_rd[p];
                win_op    = op_p[p];
                win_idx   = idx_p[p];
                win_pidx  = PW'(p);
                win_wdata = req_wdata[p*DW +: DW];
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = req_rd;
        st_d.rdata = '0;
        win_rdata = '0;
        if (win_any) begin
            if (win_rd) begin
                case (win_op)
                    OP_LOCK: begin
                        if (!st_q.held[win_idx]) begin
                            st_d.held[win_idx] = 1'b1;
                            win_rdata          = DW'(1);
                        end
                    end
                    OP_UNLOCK: st_d.held[win_idx] = 1'b0;
                    OP_STATUS: win_rdata = DW'(st_q.held);
                    OP_OWNER:  win_rdata = DW'(st_q.owner[win_idx]);
                    default:   win_rdata = '0;
                endcase
            end else if (win_op == OP_OWNER) begin
                st_d.owner[win_idx] = IDW'(win_wdata);
            end
        end
        for (int p = 0; p < NPORT; p++) begin
            if (gnt[p] && req_rd[p]) begin
                st_d.rdata[p] = win_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    logic win_lock, win_unlock, win_status, win_undef;
    assign win_lock   = win_any && win_rd && (win_op == OP_LOCK);
    assign win_unlock = win_any && win_rd && (win_op == OP_UNLOCK);
    assign win_status = win_any && win_rd && (win_op == OP_STATUS);
    assign win_undef  = win_any && win_rd && (win_op == OP_NONE);

    p_lock_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_lock && !st_q.held[win_idx]) |=>
            (st_q.held[$past(win_idx)] && st_q.rdata[$past(win_pidx)] == DW'(1)))
        else $error("p_lock_grant_r2");

    p_lock_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_lock && st_q.held[win_idx]) |=>
            (st_q.rdata[$past(win_pidx)] == '0 && st_q.held == $past(st_q.held)))
        else $error("p_lock_busy_r3");

    p_unlock_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_unlock |=> !st_q.held[$past(win_idx)])
        else $error("p_unlock_frees_r4");

    p_status_pure_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_status |=> (st_q.held == $past(st_q.held)))
        else $error("p_status_pure_r6");

    p_undef_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_undef |=> (st_q.rdata[$past(win_pidx)] == '0 &&
                       st_q.held == $past(st_q.held) &&
                       st_q.owner == $past(st_q.owner)))
        else $error("p_undef_quiet_r7");

    for (genvar p = 0; p < NPORT; p++) begin : g_lose_chk
        p_loser_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_rd[p] && !gnt[p]) |=> (st_q.vld[p] && st_q.rdata[p] == '0))
            else $error("p_loser_zero_r8");
    end
endmodule

// File: tb/hsem_bank_tb_top.sv
module hsem_bank_tb_top;
    localparam int NSEM = 8;
    localparam int NP   = 2;
    localparam int AW   = 8;
    localparam int DW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   req_rd = '0;
    logic [NP-1:0]   req_wr = '0;
    logic [NP*AW-1:0] req_addr = '0;
    logic [NP*DW-1:0] req_wdata = '0;
    logic [NP-1:0]   rsp_valid;
    logic [NP*DW-1:0] rsp_rdata;

    always #2 clk = ~clk;

    hsem_bank #(.NSEM(NSEM), .NPORT(NP), .AW(AW), .DW(DW), .IDW(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model
    bit          m_held  [NSEM];
    logic [7:0]  m_owner [NSEM];
    bit          e_vld   [NP];
    logic [31:0] e_data  [NP];
    string       e_tag   [NP];

    // kind: 0 undefined, 1 lock, 2 unlock, 3 status, 4 owner
    function automatic int kind_of(int a);
        if (a % 4 != 0) return 0;
        if (a < 8 * NSEM) return (a % 8 == 0) ? 1 : 2;
        if (a == 8 * NSEM) return 3;
        if (a >= 16 * NSEM && a < 20 * NSEM) return 4;
        return 0;
    endfunction

    function automatic int idx_of(int a);
        if (a < 8 * NSEM) return a / 8;
        return (a - 16 * NSEM) / 4;
    endfunction

    function automatic logic [31:0] status_word();
        logic [31:0] s = '0;
        for (int i = 0; i < NSEM; i++) s[i] = m_held[i];
        return s;
    endfunction

    task automatic model_step(input bit rd[NP], input bit wr[NP], input int a[NP],
                              input logic [31:0] d[NP]);
        int w = -1;
        for (int p = 0; p < NP; p++) begin
            e_vld[p]  = rd[p];
            e_data[p] = '0;
            e_tag[p]  = "R1";
            if ((rd[p] || wr[p]) && w < 0) w = p;
            else if (rd[p]) e_tag[p] = "R8";
        end
        if (w >= 0) begin
            int k = kind_of(a[w]);
            int n = idx_of(a[w]);
            if (rd[w]) begin
                if (wr[w]) e_tag[w] = "R10";
                case (k)
                    1: begin
                        if (!m_held[n]) begin
                            m_held[n] = 1'b1; e_data[w] = 32'd1;
                            if (!wr[w]) e_tag[w] = "R2";
                        end else if (!wr[w]) e_tag[w] = "R3";
                    end
                    2: begin m_held[n] = 1'b0; if (!wr[w]) e_tag[w] = "R4"; end
                    3: begin e_data[w] = status_word(); if (!wr[w]) e_tag[w] = "R6"; end
                    4: begin e_data[w] = {24'd0, m_owner[n]}; if (!wr[w]) e_tag[w] = "R5"; end
                    default: if (!wr[w]) e_tag[w] = "R7";
                endcase
            end else if (k == 4) begin
                m_owner[n] = d[w][7:0];
            end
        end
    endtask

    task automatic check_outputs();
        for (int p = 0; p < NP; p++) begin
            checks++;
            if (rsp_valid[p] !== e_vld[p] || rsp_rdata[p*DW +: DW] !== e_data[p]) begin
                failures++;
                $display("FAIL %s port%0d: valid=%0b data=%h expected valid=%0b data=%h",
                         e_tag[p], p, rsp_valid[p], rsp_rdata[p*DW +: DW], e_vld[p], e_data[p]);
            end
        end
    endtask

    // drive one cycle (called at a falling edge), then check after the rising edge
    task automatic cyc(input bit rd0, input bit wr0, input int a0, input logic [31:0] d0,
                       input bit rd1, input bit wr1, input int a1, input logic [31:0] d1);
        bit rd[NP]; bit wr[NP]; int a[NP]; logic [31:0] d[NP];
        rd[0] = rd0; wr[0] = wr0; a[0] = a0; d[0] = d0;
        rd[1] = rd1; wr[1] = wr1; a[1] = a1; d[1] = d1;
        for (int p = 0; p < NP; p++) begin
            req_rd[p] = rd[p];
            req_wr[p] = wr[p];
            req_addr[p*AW +: AW] = AW'(a[p]);
            req_wdata[p*DW +: DW] = d[p];
        end
        model_step(rd, wr, a, d);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic rd0(input int a);
        cyc(1, 0, a, 0, 0, 0, 0, 0);
    endtask

    task automatic rd1(input int a);
        cyc(0, 0, 0, 0, 1, 0, a, 0);
    endtask

    initial begin
        for (int i = 0; i < NSEM; i++) begin m_held[i] = 0; m_owner[i] = '0; end
        for (int p = 0; p < NP; p++) begin e_vld[p] = 0; e_data[p] = '0; e_tag[p] = "R9"; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state seen at the ports
        check_outputs();
        rd0(8 * NSEM);
        for (int i = 0; i < NSEM; i++) rd1(16 * NSEM + 4 * i);
        // R2 / R3: grant, then non-reentrant refusal for holder and others
        rd0(0);
        rd0(0);
        rd1(0);
        // R5: owner write keeps low 8 bits, read back
        cyc(0, 1, 16 * NSEM, 32'h1A5, 0, 0, 0, 0);
        rd1(16 * NSEM);
        // R4: release from the other port, then release when already free
        rd1(4);
        rd0(8 * NSEM);
        rd1(4);
        rd0(8 * NSEM);
        rd1(16 * NSEM);
        // R2 / R6: take every mutex, free the odd ones
        for (int i = 0; i < NSEM; i++) rd0(8 * i);
        rd1(8 * NSEM);
        for (int i = 1; i < NSEM; i += 2) rd1(8 * i + 4);
        rd0(8 * NSEM);
        // R7: undefined and unaligned reads, writes to non-owner offsets
        rd0(8 * NSEM + 4);
        rd0(16 * NSEM - 4);
        rd0(1);
        rd0(6);
        rd0(20 * NSEM);
        rd0(255);
        cyc(0, 1, 8, 32'hFFFF_FFFF, 0, 0, 0, 0);
        cyc(0, 1, 12, 32'h1, 0, 1, 8 * NSEM, 32'hFF);
        cyc(0, 1, 16 * NSEM + 2, 32'h77, 0, 0, 0, 0);
        rd0(8 * NSEM);
        rd0(16 * NSEM);
        // R8: simultaneous lock of a free mutex, lower port wins
        rd0(8 * 1 + 4);
        cyc(1, 0, 8 * 1, 0, 1, 0, 8 * 1, 0);
        cyc(0, 1, 16 * NSEM + 4, 32'h11, 1, 0, 16 * NSEM + 4, 0);
        cyc(0, 1, 16 * NSEM + 8, 32'h22, 0, 1, 16 * NSEM + 8, 32'h33);
        cyc(1, 0, 8 * 1 + 4, 0, 1, 0, 8 * NSEM, 0);
        rd1(16 * NSEM + 8);
        rd1(8 * NSEM);
        // R10: read and write together on one port
        cyc(1, 1, 16 * NSEM + 12, 32'h44, 0, 0, 0, 0);
        rd0(16 * NSEM + 12);
        cyc(1, 1, 8 * 3, 32'h0, 0, 0, 0, 0);
        rd0(8 * NSEM);
        // random mix
        for (int it = 0; it < 4000; it++) begin
            bit r[NP]; bit w[NP]; int a[NP]; logic [31:0] d[NP];
            for (int p = 0; p < NP; p++) begin
                int sel = $urandom_range(0, 9);
                int n   = $urandom_range(0, NSEM - 1);
                r[p] = ($urandom_range(0, 3) != 0);
                w[p] = ($urandom_range(0, 3) == 0);
                d[p] = $urandom();
                case (sel)
                    0, 1, 2: a[p] = 8 * n;
                    3, 4:    a[p] = 8 * n + 4;
                    5:       a[p] = 8 * NSEM;
                    6, 7:    a[p] = 16 * NSEM + 4 * n;
                    default: a[p] = $urandom_range(0, 255);
                endcase
            end
            cyc(r[0], w[0], a[0], d[0], r[1], w[1], a[1], d[1]);
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule